// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shared Time Base and Break Protection

The block produces up to four pulse-width-modulated outputs from one shared time base. A prescaler divides the clock, and an up-counter runs from zero to an auto-reload limit and then wraps. Each channel compares the counter against its own compare value and drives a main output and an optional complementary output. Each of the two outputs has its own polarity bit. The reload value can be preloaded and the compare values are always preloaded. Preloaded values reach the working copies only on an update event: either a counter wrap or an update that software forces.

A main output enable gates every output. Two break inputs can clear it in hardware. Each break input has its own enable, active level and digital filter. A recognised break drives every output to its idle level, and the outputs stay there until software sets the main output enable again. All settings sit behind a simple write strobe and a combinational read port.

Register map (4-bit address, 32-bit data):

- 0 control: bit0 count enable, bit1 reload preload enable, bit2 main output enable, bit3 force update (write-only pulse, reads 0).
- 1 prescaler P.
- 2 reload R.
- 3 channel config: one nibble per channel slot, with slot c at bits 4c..4c+3 = {complementary polarity, complementary enable, polarity, enable}.
- 4 break config: break b at byte b = {filter[3:0] at bits 8b+5..8b+2, level at 8b+1, enable at 8b}.
- 5 counter value (read-only).
- 8+c compare value of channel c.

Top module: `quad_pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter reads 0, and all main and complementary outputs are 0.
- R2: With polarity 0, a channel's main output is high while the counter is below its compare value C. The period is (P+1)·(R+1) clocks and the high time is (P+1)·C clocks.
- R3: A compare value of 0 keeps the main output at its idle level, and a compare value above R keeps it active for the whole period.
- R4: The polarity bit inverts the main output. When enabled, the complementary output is the inverse of the reference and its own polarity bit inverts it.
- R5: With reload preload enable set, a reload write takes effect only at the next update event. With it clear, the new value applies one cycle after the write.
- R6: A compare write takes effect only at the next update event, so the period that is running keeps its old high time.
- R7: Writing 1 to the force-update bit clears the prescaler and the counter on the clock edge of the write, and moves the preloaded reload and compare values into the working copies on the same edge.
- R8: Unless main output enable, count enable and the channel enable are all 1, the main output sits at its polarity bit. The complementary output also needs its own enable and otherwise sits at its complementary polarity bit. With count enable 0 the counter holds its value.
- R9: A break input with filter N is recognised only when it has been sampled at its active level for 2N consecutive cycles and is still active in the next one. A shorter pulse, a disabled break input and the non-active level have no effect. With N=0 the main output enable reads 0 two cycles after the input changes.
- R10: A recognised break clears main output enable. While the break is still recognised, a software write of 1 to main output enable is overridden. After the break input is released, writing 1 restores the outputs.
- R11: Channel config bits and compare registers of slots at or above the implemented channel count ignore writes and read back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| brk_i | input | 2 | Break inputs |
| pwm_o | output | NUM_CH | Main PWM outputs |
| pwm_n_o | output | NUM_CH | Complementary PWM outputs |

## Verification
The outputs are combinational from the counter, so a force update shows in the counter and outputs one edge after the write. A reload written with preload disabled reaches the working copy one edge later still. A break reaches the main output enable 2N+2 edges after the input changes: one sampling register, 2N filter counts, and the enable register. The bench drives and samples on falling edges and counts edges in exactly these terms. Period and high time are measured between two detected rising edges of an output, so the checks do not depend on counter phase. The filter and override checks sample the cycle before and the cycle at which main output enable is due to fall.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NUM_BRK = 2;
  localparam int FILT_W  = 4;
  localparam int MAX_SLOTS = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC    = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CHCFG  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_BRK    = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_CNT    = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_CMP0   = 4'd8;

  // control bit positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_ARPE  = 1;
  localparam int CTL_MOE   = 2;
  localparam int CTL_FORCE = 3;

  // position of a field inside a channel nibble
  localparam int CH_EN   = 0;
  localparam int CH_POL  = 1;
  localparam int CH_CEN  = 2;
  localparam int CH_NPOL = 3;

  // reference level: active while the count is below the compare value
  function automatic logic ref_active(input logic [31:0] cnt, input logic [31:0] cmp);
    return cnt < cmp;
  endfunction

  // consecutive active samples demanded by filter setting n
  function automatic int unsigned filt_span(input int unsigned n);
    return n * 2;
  endfunction
endpackage

// File: rtl/pwm_break_filter.sv
module pwm_break_filter
  import pwm_tmr_pkg::*;
#(
  parameter int FW = FILT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_i,
  input  logic          en_i,
  input  logic          lvl_i,
  input  logic [FW-1:0] filt_i,
  output logic          trip_o
);
  localparam int RUN_W = FW + 2;

  logic             smp_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] lim;
  logic             active;

  assign lim    = RUN_W'(filt_span(32'(filt_i)));
  assign active = en_i && (smp_q == lvl_i);
  assign trip_o = active && (run_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      run_q <= '0;
    end else begin
      smp_q <= brk_i;
      if (!active)
        run_q <= '0;
      else if (run_q < lim)
        run_q <= run_q + 1'b1;
    end
  end

  AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && filt_i != '0) |-> $past(active)); // R9
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run_i,
  input  logic                         arpe_i,
  input  logic                         force_i,
  input  logic [PSC_W-1:0]             psc_i,
  input  logic [CNT_W-1:0]             reload_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_sh_o,
  output logic                         upd_o
);
  logic [PSC_W-1:0]             pc_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             reload_sh;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_sh;
  logic tick, wrap, upd_evt;

  assign tick    = run_i && (pc_q >= psc_i);
  assign wrap    = tick && (cnt_q >= reload_sh);
  assign upd_evt = force_i || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (force_i) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        pc_q  <= '0;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reload_sh <= '0;
    else if (upd_evt || !arpe_i)
      reload_sh <= reload_i;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_sh[i] <= '0;
      else if (upd_evt)
        cmp_sh[i] <= cmp_i[i];
    end
  end

  assign cnt_o    = cnt_q;
  assign cmp_sh_o = cmp_sh;
  assign upd_o    = upd_evt;

  AST_UPD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (cnt_q == '0)); // R7
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(cmp_sh)); // R6
  AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arpe_i && !upd_evt) |=> $stable(reload_sh)); // R5
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !force_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             gate_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic             cen_i,
  input  logic             npol_i,
  output logic             pwm_o,
  output logic             pwm_n_o
);
  logic ref_lvl, main_on, comp_on;

  assign ref_lvl = ref_active(32'(cnt_i), 32'(cmp_i));
  assign main_on = gate_i && en_i;
  assign comp_on = main_on && cen_i;
  assign pwm_o   = main_on ? (ref_lvl ^ pol_i) : pol_i;
  assign pwm_n_o = comp_on ? (~ref_lvl ^ npol_i) : npol_i;

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |-> (pwm_o == pol_i && pwm_n_o == npol_i)); // R8
  AST_COMP_OPPOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_on && pol_i == npol_i) |-> (pwm_o != pwm_n_o)); // R4
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [NUM_BRK-1:0]           trip_i,
  output logic                         run_o,
  output logic                         arpe_o,
  output logic                         moe_o,
  output logic                         force_o,
  output logic [PSC_W-1:0]             psc_o,
  output logic [CNT_W-1:0]             reload_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [NUM_CH-1:0]            ch_en_o,
  output logic [NUM_CH-1:0]            pol_o,
  output logic [NUM_CH-1:0]            cen_o,
  output logic [NUM_CH-1:0]            npol_o,
  output logic [NUM_BRK-1:0]           brk_en_o,
  output logic [NUM_BRK-1:0]           brk_lvl_o,
  output logic [NUM_BRK-1:0][FILT_W-1:0] brk_filt_o
);
  localparam int CFG_W = 4 * NUM_CH;

  logic                         run_q, arpe_q, moe_q;
  logic [PSC_W-1:0]             psc_q;
  logic [CNT_W-1:0]             reload_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [CFG_W-1:0]             cfg_q;
  logic [NUM_BRK-1:0]           ben_q, blvl_q;
  logic [NUM_BRK-1:0][FILT_W-1:0] bfilt_q;
  logic                         wr_ctrl, brk_hit;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign brk_hit = |trip_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      arpe_q   <= 1'b0;
      psc_q    <= '0;
      reload_q <= '0;
      cfg_q    <= '0;
      ben_q    <= '0;
      blvl_q   <= '0;
      bfilt_q  <= '0;
      cmp_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_CTRL: begin
          run_q  <= wdata[CTL_RUN];
          arpe_q <= wdata[CTL_ARPE];
        end
        ADDR_PSC:    psc_q    <= wdata[PSC_W-1:0];
        ADDR_RELOAD: reload_q <= wdata[CNT_W-1:0];
        ADDR_CHCFG:  cfg_q    <= wdata[CFG_W-1:0];
        ADDR_BRK: begin
          for (int b = 0; b < NUM_BRK; b++) begin
            ben_q[b]   <= wdata[8*b];
            blvl_q[b]  <= wdata[8*b+1];
            bfilt_q[b] <= wdata[8*b+2 +: FILT_W];
          end
        end
        default: begin
          for (int i = 0; i < NUM_CH; i++)
            if (addr == ADDR_CMP0 + ADDR_W'(i))
              cmp_q[i] <= wdata[CNT_W-1:0];
        end
      endcase
    end
  end

  // main output enable: a recognised break wins over a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      moe_q <= 1'b0;
    else if (brk_hit)
      moe_q <= 1'b0;
    else if (wr_ctrl)
      moe_q <= wdata[CTL_MOE];
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_CTRL: begin
        rd_data[CTL_RUN]  = run_q;
        rd_data[CTL_ARPE] = arpe_q;
        rd_data[CTL_MOE]  = moe_q;
      end
      ADDR_PSC:    rd_data[PSC_W-1:0] = psc_q;
      ADDR_RELOAD: rd_data[CNT_W-1:0] = reload_q;
      ADDR_CHCFG:  rd_data[CFG_W-1:0] = cfg_q;
      ADDR_BRK: begin
        for (int b = 0; b < NUM_BRK; b++) begin
          rd_data[8*b]              = ben_q[b];
          rd_data[8*b+1]            = blvl_q[b];
          rd_data[8*b+2 +: FILT_W]  = bfilt_q[b];
        end
      end
      ADDR_CNT: rd_data[CNT_W-1:0] = cnt_i;
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr == ADDR_CMP0 + ADDR_W'(i))
            rd_data[CNT_W-1:0] = cmp_q[i];
      end
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign ch_en_o[c] = cfg_q[4*c+CH_EN];
    assign pol_o[c]   = cfg_q[4*c+CH_POL];
    assign cen_o[c]   = cfg_q[4*c+CH_CEN];
    assign npol_o[c]  = cfg_q[4*c+CH_NPOL];
  end

  assign run_o      = run_q;
  assign arpe_o     = arpe_q;
  assign moe_o      = moe_q;
  assign force_o    = wr_ctrl && wdata[CTL_FORCE];
  assign psc_o      = psc_q;
  assign reload_o   = reload_q;
  assign cmp_o      = cmp_q;
  assign brk_en_o   = ben_q;
  assign brk_lvl_o  = blvl_q;
  assign brk_filt_o = bfilt_q;

  AST_BREAK_DROPS_MOE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> !moe_q); // R10
  AST_MOE_RISES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_q) |-> $past(wr_ctrl && !brk_hit)); // R10
endmodule

// File: rtl/quad_pwm_timer.sv
module quad_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  input  logic [1:0]        brk_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_n_o
);
  logic                         run, arpe, moe, force_upd, upd;
  logic [PSC_W-1:0]             psc;
  logic [CNT_W-1:0]             reload, cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp, cmp_sh;
  logic [NUM_CH-1:0]            ch_en, pol, cen, npol;
  logic [NUM_BRK-1:0]           brk_en, brk_lvl, trip;
  logic [NUM_BRK-1:0][FILT_W-1:0] brk_filt;
  logic                         gate;

  pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .cnt_i(cnt), .trip_i(trip),
    .run_o(run), .arpe_o(arpe), .moe_o(moe), .force_o(force_upd),
    .psc_o(psc), .reload_o(reload), .cmp_o(cmp),
    .ch_en_o(ch_en), .pol_o(pol), .cen_o(cen), .npol_o(npol),
    .brk_en_o(brk_en), .brk_lvl_o(brk_lvl), .brk_filt_o(brk_filt)
  );

  pwm_timebase #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_i(run), .arpe_i(arpe), .force_i(force_upd),
    .psc_i(psc), .reload_i(reload), .cmp_i(cmp),
    .cnt_o(cnt), .cmp_sh_o(cmp_sh), .upd_o(upd)
  );

  for (genvar b = 0; b < NUM_BRK; b++) begin : g_brk
    pwm_break_filter #(.FW(FILT_W)) u_brk (
      .clk(clk), .rst_n(rst_n), .brk_i(brk_i[b]), .en_i(brk_en[b]),
      .lvl_i(brk_lvl[b]), .filt_i(brk_filt[b]), .trip_o(trip[b])
    );
  end

  assign gate = moe && run;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cmp_i(cmp_sh[c]), .gate_i(gate),
      .en_i(ch_en[c]), .pol_i(pol[c]), .cen_i(cen[c]), .npol_i(npol[c]),
      .pwm_o(pwm_o[c]), .pwm_n_o(pwm_n_o[c])
    );
  end

  AST_WRAP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !force_upd) |-> run); // R2
endmodule

// File: tb/quad_pwm_timer_tb.sv
module quad_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rd_data;
  logic [1:0]  brk_i = 2'b00;
  logic [3:0]  pwm_o, pwm_n_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  quad_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .brk_i(brk_i), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    bit prev;
    prev = pwm_o[ch];
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!prev && pwm_o[ch]) begin ok = 1'b1; break; end
      prev = pwm_o[ch];
    end
  endtask

  // measures one full period and its high time, starting at a rising edge
  task automatic measure(input int ch, output int per, output int hi);
    bit ok, prev;
    per = 0; hi = 0;
    wait_rise(ch, ok);
    if (!ok) return;
    prev = 1'b1; per = 1; hi = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!prev && pwm_o[ch]) break;
      prev = pwm_o[ch];
      per++;
      if (pwm_o[ch]) hi++;
    end
  endtask

  task automatic setup(input int p, input int r, input int c, input logic [31:0] cfg, input bit arpe);
    wr(4'd1, p);
    wr(4'd2, r);
    wr(4'd8, c);
    wr(4'd3, cfg);
    wr(4'd0, 32'h0000_000D | (32'(arpe) << 1)); // run, moe, force
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd0, d); check(d == 0, "R1 control", d, 0);
    rd(4'd5, d); check(d == 0, "R1 counter", d, 0);
    rd(4'd8, d); check(d == 0, "R1 compare", d, 0);
    check(pwm_o == 0 && pwm_n_o == 0, "R1 outputs", {pwm_o, pwm_n_o}, 0);
  endtask

  task automatic t_absent;
    logic [31:0] d;
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); check(d == 32'h0000_FFFF, "R11 config slots", d, 32'hFFFF);
    wr(4'd12, 32'd77);
    rd(4'd12, d); check(d == 0, "R11 absent compare", d, 0);
    wr(4'd3, 32'd0);
  endtask

  task automatic t_period;
    int per, hi;
    setup(0, 9, 4, 32'h1, 1'b0);
    measure(0, per, hi);
    check(per == 10, "R2 period P0", per, 10);
    check(hi == 4, "R2 high P0", hi, 4);
    setup(2, 5, 3, 32'h1, 1'b0);
    measure(0, per, hi);
    check(per == 18, "R2 period P2", per, 18);
    check(hi == 9, "R2 high P2", hi, 9);
  endtask

  task automatic t_extremes;
    int hi;
    setup(0, 9, 0, 32'h1, 1'b0);
    hi = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (pwm_o[0]) hi++; end
    check(hi == 0, "R3 compare zero", hi, 0);
    setup(0, 9, 10, 32'h1, 1'b0);
    hi = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (pwm_o[0]) hi++; end
    check(hi == 40, "R3 compare above reload", hi, 40);
  endtask

  task automatic t_polarity;
    int per, hi, bad;
    setup(0, 9, 4, 32'h5, 1'b0); // en, comp en
    bad = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (pwm_o[0] == pwm_n_o[0]) bad++; end
    check(bad == 0, "R4 complementary opposes", bad, 0);
    setup(0, 9, 4, 32'h7, 1'b0); // main inverted
    measure(0, per, hi);
    check(hi == 6, "R4 inverted high time", hi, 6);
    bad = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (pwm_o[0] != pwm_n_o[0]) bad++; end
    check(bad == 0, "R4 one side inverted", bad, 0);
    setup(0, 9, 4, 32'hF, 1'b0); // both inverted
    bad = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (pwm_o[0] == pwm_n_o[0]) bad++; end
    check(bad == 0, "R4 both inverted", bad, 0);
  endtask

  task automatic t_reload(input bit arpe, input int exp);
    bit ok, prev;
    int n;
    setup(0, 9, 2, 32'h1, arpe);
    wait_rise(0, ok);
    wr(4'd2, 32'd4);
    n = 1; prev = pwm_o[0];
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); n++;
      if (!prev && pwm_o[0]) break;
      prev = pwm_o[0];
    end
    check(ok && n == exp, arpe ? "R5 preload on" : "R5 preload off", n, exp);
  endtask

  task automatic t_cmp_preload;
    bit ok;
    int hi, per;
    setup(0, 9, 6, 32'h1, 1'b0);
    wait_rise(0, ok);
    wr(4'd8, 32'd2);
    hi = 2;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_o[0]) hi++; else break; end
    check(ok && hi == 6, "R6 running period keeps compare", hi, 6);
    measure(0, per, hi);
    check(hi == 2, "R6 next period new compare", hi, 2);
  endtask

  task automatic t_force;
    logic [31:0] d;
    int mx;
    setup(99, 50, 10, 32'h1, 1'b1);
    repeat (300) @(negedge clk);
    rd(4'd5, d); check(d != 0, "R7 counter running", d, 3);
    wr(4'd0, 32'h0000_000F);
    rd(4'd5, d); check(d == 0, "R7 force clears counter", d, 0);
    setup(0, 200, 1, 32'h1, 1'b1);
    repeat (5) @(negedge clk);
    wr(4'd2, 32'd3);
    wr(4'd0, 32'h0000_000F);
    mx = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); rd(4'd5, d); if (d > mx) mx = d;
    end
    check(mx == 3, "R7 force loads reload", mx, 3);
  endtask

  task automatic t_gate;
    logic [31:0] d0, d1;
    int bad;
    setup(0, 9, 4, 32'h7, 1'b0);
    wr(4'd0, 32'h0000_0001); // run, moe off
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); if (pwm_o[0] != 1'b1 || pwm_n_o[0] != 1'b0) bad++;
    end
    check(bad == 0, "R8 idle without main enable", bad, 0);
    wr(4'd0, 32'h0000_0004); // moe, counter stopped
    rd(4'd5, d0);
    repeat (7) @(negedge clk);
    rd(4'd5, d1);
    check(d0 == d1, "R8 counter holds", d1, d0);
    check(pwm_o[0] == 1'b1 && pwm_n_o[0] == 1'b0, "R8 idle while stopped", pwm_o[0], 1);
    wr(4'd3, 32'h0000_0003); // en, pol, comp disabled
    wr(4'd0, 32'h0000_0005);
    bad = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_n_o[0] != 1'b0) bad++; end
    check(bad == 0, "R8 complementary disabled idle", bad, 0);
  endtask

  task automatic t_break;
    logic [31:0] d;
    int per, hi;
    setup(0, 9, 4, 32'h1, 1'b0);
    wr(4'd4, 32'h0000_000B); // break0 en, level 1, filter 2
    brk_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    brk_i[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b1, "R9 short pulse ignored", d[2], 1);
    brk_i[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b1, "R9 not yet filtered", d[2], 1);
    @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b0, "R9 break after filter", d[2], 0);
    check(pwm_o[0] == 1'b0, "R10 output idle on break", pwm_o[0], 0);
    wr(4'd0, 32'h0000_0005);
    rd(4'd0, d); check(d[2] == 1'b0, "R10 break overrides enable", d[2], 0);
    brk_i[0] = 1'b0;
    repeat (3) @(negedge clk);
    wr(4'd0, 32'h0000_0005);
    rd(4'd0, d); check(d[2] == 1'b1, "R10 enable restored", d[2], 1);
    measure(0, per, hi);
    check(hi == 4, "R10 output resumes", hi, 4);
    wr(4'd4, 32'h0000_000A); // break0 disabled
    brk_i[0] = 1'b1;
    repeat (40) @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b1, "R9 disabled break ignored", d[2], 1);
    brk_i[0] = 1'b0;
    brk_i[1] = 1'b1;
    wr(4'd4, 32'h0000_0100); // break1 en, level 0, filter 0
    repeat (20) @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b1, "R9 inactive level ignored", d[2], 1);
    brk_i[1] = 1'b0;
    @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b1, "R9 unfiltered one cycle", d[2], 1);
    @(negedge clk);
    rd(4'd0, d); check(d[2] == 1'b0, "R9 unfiltered low level break", d[2], 0);
    brk_i[1] = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_absent();
    t_period();
    t_extremes();
    t_polarity();
    t_reload(1'b1, 10);
    t_reload(1'b0, 5);
    t_cmp_preload();
    t_force();
    t_gate();
    t_break();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule